// File: doc/BRIEF.md
# Tri-Level Pulse Up/Down Trimmer

This block turns pulses on a single three-level control pin into unit steps of a 7-bit trim code. Two external comparators report whether the pin has left its idle mid level towards a high level or towards a low level. Both indications are synchronized into the block clock. The block measures how long each excursion lasts. When the pin returns to mid, it issues one step up for a high excursion or one step down for a low excursion. A step is issued only if the excursion lasted long enough. The trim code feeds a current-sink DAC, and it saturates at both ends of its range.

Adjustment is accepted only while the enable input is high. The first qualified pulse after reset is thrown away, because the comparators come up in an unknown state. A simultaneous high and low indication is treated as an invalid pin state. A restore controller can overwrite the code through a load port, for example with a value read back from non-volatile storage.

The sequencer is a five-state machine:
- OFF: enable is low. No pulse is tracked.
- REARM: the machine waits for the pin to settle at mid before tracking begins.
- IDLE: the pin is at mid.
- UP: a high excursion is being timed.
- DN: a low excursion is being timed.

Transitions:
- OFF to REARM when enable rises.
- Any state to OFF when enable falls.
- REARM to IDLE when both indications are clear.
- IDLE to UP on a high-only indication, and IDLE to DN on a low-only indication.
- IDLE to REARM when both indications are set.
- UP or DN to IDLE on return to mid. This transition emits a step if the excursion qualified.
- UP or DN to REARM on any other change of the pin level.

Top module: `trim_ctl`

## Requirements
- R1: After reset the trim code equals RESET_CODE (default 64, mid-scale), and the first-pulse discard is armed.
- R2: A high-only excursion (cmp_hi=1, cmp_lo=0) that lasts at least MIN_CYCLES synchronized cycles and then returns to mid (both 0) raises the code by exactly 1, once.
- R3: A low-only excursion (cmp_lo=1, cmp_hi=0) that lasts at least MIN_CYCLES and then returns to mid lowers the code by exactly 1, once.
- R4: The code saturates. A step up at 127 leaves it at 127, and a step down at 0 leaves it at 0.
- R5: An excursion shorter than MIN_CYCLES (MIN_CYCLES = CLK_KHZ*REJECT_US/1000) changes nothing. One of exactly MIN_CYCLES is accepted.
- R6: Only the first qualified excursion after reset is discarded. Rejected glitches do not use up the discard, and later qualified excursions count normally.
- R7: While en is low, no excursion changes the code. An excursion already present when en rises is not counted; tracking resumes only after the pin has returned to mid.
- R8: When cmp_hi and cmp_lo are both 1 at any point, the current excursion produces no step. Tracking resumes only after both are 0.
- R9: A pin held at mid (both indications 0) produces no steps for any length of time.
- R10: With load_en=1 the code takes load_code at the next clock edge, even when a step falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| en | input | 1 | Adjustment enable, synchronous to clk |
| cmp_hi | input | 1 | Asynchronous comparator: pin above the high threshold |
| cmp_lo | input | 1 | Asynchronous comparator: pin below the low threshold |
| load_en | input | 1 | Overwrite the trim code with load_code |
| load_code | input | 7 | Value to load |
| trim_code | output | 7 | Current trim code to the DAC |

## Verification
The assertions check the following on every cycle:
- the code never moves by more than one step except through a load;
- the code never wraps past either end;
- a load always wins;
- no step is issued while enable is low or while both comparator indications are set.

The assertions cannot show pulse-width qualification at the exact boundary, the discard of the first pulse, re-arming after enable rises or after an invalid state, or the net count over long up and down ramps. Only the bench scenarios show these, by comparing the code against an arithmetic model after each pulse.

// File: rtl/trim_pkg.sv
package trim_pkg;
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_REARM = 3'd1,
        ST_IDLE  = 3'd2,
        ST_UP    = 3'd3,
        ST_DN    = 3'd4
    } trim_state_e;
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= '0;
                end else if (g == 0) begin
                    chain[g] <= d;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/trim_pulse_fsm.sv
module trim_pulse_fsm
    import trim_pkg::*;
#(
    parameter int MIN_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hi_s,
    input  logic lo_s,
    output logic step_up,
    output logic step_dn
);
    localparam int CW = $clog2(MIN_CYCLES + 1);
    localparam logic [CW-1:0] WMAX = CW'(MIN_CYCLES);

    trim_state_e state_q, state_d;
    logic [CW-1:0] width_q, width_d;
    logic          armed_q, armed_d;
    logic          at_mid, only_hi, only_lo, qual;

    assign at_mid  = !hi_s && !lo_s;
    assign only_hi = hi_s && !lo_s;
    assign only_lo = lo_s && !hi_s;
    assign qual    = (width_q >= WMAX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            width_q <= '0;
            armed_q <= 1'b1;
        end else begin
            state_q <= state_d;
            width_q <= width_d;
            armed_q <= armed_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        width_d = '0;
        unique case (state_q)
            ST_OFF: begin
                if (en) state_d = ST_REARM;
            end
            ST_REARM: begin
                if (!en)         state_d = ST_OFF;
                else if (at_mid) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (!en) begin
                    state_d = ST_OFF;
                end else if (only_hi) begin
                    state_d = ST_UP;
                    width_d = CW'(1);
                end else if (only_lo) begin
                    state_d = ST_DN;
                    width_d = CW'(1);
                end else if (hi_s && lo_s) begin
                    state_d = ST_REARM;
                end
            end
            ST_UP, ST_DN: begin
                if (!en) begin
                    state_d = ST_OFF;
                end else if ((state_q == ST_UP && only_hi) ||
                             (state_q == ST_DN && only_lo)) begin
                    width_d = (width_q == WMAX) ? WMAX : width_q + CW'(1);
                end else if (at_mid) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_REARM;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        armed_d = armed_q;
        if (en && at_mid && qual && (state_q == ST_UP || state_q == ST_DN)) begin
            if (armed_q) begin
                armed_d = 1'b0;
            end else begin
                step_up = (state_q == ST_UP);
                step_dn = (state_q == ST_DN);
            end
        end
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!step_up && !step_dn)); // R7
    AST_BOTH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_s && lo_s) |-> (!step_up && !step_dn)); // R8
    AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn)); // R2
    AST_MID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!step_up && !step_dn)); // R9
endmodule

// File: rtl/trim_counter.sv
module trim_counter #(
    parameter int WIDTH      = 7,
    parameter int RESET_CODE = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up,
    input  logic             dn,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] code
);
    localparam logic [WIDTH-1:0] MAXC = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] MINC = '0;

    logic [WIDTH-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= WIDTH'(RESET_CODE);
        end else if (load_en) begin
            code_q <= load_val;
        end else if (up && code_q != MAXC) begin
            code_q <= code_q + WIDTH'(1);
        end else if (dn && code_q != MINC) begin
            code_q <= code_q - WIDTH'(1);
        end
    end

    assign code = code_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && up && code_q == MAXC) |=> (code_q == MAXC)); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && dn && code_q == MINC) |=> (code_q == MINC)); // R4
    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ((code_q == $past(code_q)) ||
                      (code_q == $past(code_q) + WIDTH'(1)) ||
                      (code_q == $past(code_q) - WIDTH'(1)))); // R2
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (code_q == $past(load_val))); // R10
endmodule

// File: rtl/trim_ctl.sv
module trim_ctl #(
    parameter int CLK_KHZ    = 250000,
    parameter int REJECT_US  = 20,
    parameter int CODE_W     = 7,
    parameter int RESET_CODE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cmp_hi,
    input  logic              cmp_lo,
    input  logic              load_en,
    input  logic [CODE_W-1:0] load_code,
    output logic [CODE_W-1:0] trim_code
);
    localparam int MIN_CYCLES = (CLK_KHZ * REJECT_US) / 1000;

    logic [1:0] cmp_s;
    logic       step_up, step_dn;

    trim_sync #(.W(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cmp_hi, cmp_lo}),
        .q     (cmp_s)
    );

    trim_pulse_fsm #(.MIN_CYCLES(MIN_CYCLES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .hi_s    (cmp_s[1]),
        .lo_s    (cmp_s[0]),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    trim_counter #(.WIDTH(CODE_W), .RESET_CODE(RESET_CODE)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .up       (step_up),
        .dn       (step_dn),
        .load_en  (load_en),
        .load_val (load_code),
        .code     (trim_code)
    );
endmodule

// File: tb/sim_trim_ctl.sv
module sim_trim_ctl;
    localparam int MINC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       cmp_hi = 1'b0;
    logic       cmp_lo = 1'b0;
    logic       load_en = 1'b0;
    logic [6:0] load_code = '0;
    logic [6:0] trim_code;

    int checks = 0;
    int errors = 0;
    int expv = 64;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trim_ctl #(.CLK_KHZ(400), .REJECT_US(20), .CODE_W(7), .RESET_CODE(64)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
        .load_en(load_en), .load_code(load_code), .trim_code(trim_code)
    );

    task automatic check(input string req, input int exp);
        checks++;
        if (int'(trim_code) != exp) begin
            errors++;
            $display("FAIL %s: trim_code=%0d expected=%0d", req, trim_code, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive one excursion of n cycles, then return to mid and settle
    task automatic pulse(input bit hi, input bit lo, input int n);
        @(negedge clk);
        cmp_hi = hi;
        cmp_lo = lo;
        idle(n);
        cmp_hi = 1'b0;
        cmp_lo = 1'b0;
        idle(6);
    endtask

    task automatic do_load(input int v);
        @(negedge clk);
        load_en = 1'b1;
        load_code = 7'(v);
        @(negedge clk);
        load_en = 1'b0;
        idle(2);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        check("R1 reset code", 64);
        en = 1'b1;
        idle(4);
        pulse(1'b1, 1'b0, 3);
        check("R6 glitch before first pulse", 64);
        pulse(1'b1, 1'b0, MINC);
        check("R6 first qualified pulse dropped", 64);
        pulse(1'b1, 1'b0, MINC + 4);
        expv = 65;
        check("R2 up step", expv);
        pulse(1'b1, 1'b0, MINC - 1);
        check("R5 up one short", expv);
        pulse(1'b1, 1'b0, MINC);
        expv++;
        check("R5 up exact width", expv);
        pulse(1'b0, 1'b1, MINC - 1);
        check("R5 down one short", expv);
        pulse(1'b0, 1'b1, MINC);
        expv--;
        check("R3 down step", expv);
        pulse(1'b1, 1'b1, 12);
        check("R8 both set", expv);
        // high then both, then mid
        @(negedge clk);
        cmp_hi = 1'b1;
        idle(MINC + 2);
        cmp_lo = 1'b1;
        idle(3);
        cmp_lo = 1'b0;
        idle(MINC + 2);
        cmp_hi = 1'b0;
        idle(6);
        check("R8 invalid aborts pulse", expv);
        pulse(1'b1, 1'b0, MINC);
        expv++;
        check("R8 recovers after invalid", expv);
        idle(300);
        check("R9 mid idle", expv);
        // disabled
        en = 1'b0;
        idle(2);
        pulse(1'b1, 1'b0, MINC + 5);
        pulse(1'b0, 1'b1, MINC + 5);
        check("R7 disabled pulses", expv);
        // enable rises mid-excursion
        @(negedge clk);
        cmp_hi = 1'b1;
        idle(4);
        en = 1'b1;
        idle(MINC + 4);
        cmp_hi = 1'b0;
        idle(6);
        check("R7 pulse started before enable", expv);
        // enable falls mid-excursion
        @(negedge clk);
        cmp_lo = 1'b1;
        idle(MINC + 2);
        en = 1'b0;
        idle(2);
        cmp_lo = 1'b0;
        idle(6);
        en = 1'b1;
        idle(4);
        check("R7 enable dropped during pulse", expv);
        pulse(1'b0, 1'b1, MINC);
        expv--;
        check("R7 counts after re-enable", expv);
        // width sweep
        for (int w = 1; w <= MINC + 4; w++) begin
            pulse(1'b1, 1'b0, w);
            if (w >= MINC) expv++;
            check("R5 width sweep", expv);
        end
        // load then ramp to ceiling
        do_load(120);
        expv = 120;
        check("R10 load", expv);
        for (int i = 0; i < 10; i++) begin
            pulse(1'b1, 1'b0, MINC);
            if (expv < 127) expv++;
            check("R4 ramp to ceiling", expv);
        end
        do_load(5);
        expv = 5;
        for (int i = 0; i < 8; i++) begin
            pulse(1'b0, 1'b1, MINC);
            if (expv > 0) expv--;
            check("R4 ramp to floor", expv);
        end
        // full up sweep and down sweep
        for (int i = 0; i < 130; i++) begin
            pulse(1'b1, 1'b0, MINC);
            if (expv < 127) expv++;
        end
        check("R4 full ramp up", 127);
        for (int i = 0; i < 130; i++) begin
            pulse(1'b0, 1'b1, MINC);
            if (expv > 0) expv--;
        end
        check("R4 full ramp down", 0);
        // load in the same cycle as a step
        do_load(40);
        @(negedge clk);
        cmp_hi = 1'b1;
        idle(MINC + 1);
        cmp_hi = 1'b0;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        load_en = 1'b1;
        load_code = 7'd90;
        @(negedge clk);
        load_en = 1'b0;
        idle(6);
        check("R10 load beats step", 90);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule